// File: doc/BRIEF.md
# Buffer Descriptor Ring Walker

This block walks a circular ring of buffer descriptors held in system memory on behalf of one direction of a network controller, receive or transmit, selected by a tie-off input. Software places the ring anywhere in a 24-bit byte address space on an 8-byte boundary and gives its size as a 3-bit code meaning 2^code entries. Each descriptor is four 16-bit words. The walker reaches memory only through a simple request/acknowledge port that moves one 16-bit word at a time.

When the consumer pulses a fetch request, the walker reads the status word of the descriptor at its current index. A clear ownership bit means the host still holds the entry. The walker then reports it as empty and stays on that index. A set ownership bit means the device owns the entry. The walker then reads the address and length words and presents the buffer address, the positive buffer length and the packet start and end flags. After the consumer finishes with the buffer, it pulses a completion request carrying its status. The walker writes the last descriptor word first. It then writes the status word with the ownership bit cleared, which hands the entry back to the host, and moves to the next index, wrapping at the end of the ring.

Top module: `ring_walker`

## Requirements
- R1: While reset is asserted and right after it, desc_valid and mem_req are 0 and ring_idx is 0.
- R2: Every access goes to byte address (ring_base with bits 2:0 forced to 0) + ring_idx*8 + 2*w, where w is the word number 0..3. A fetch always starts with a read of word 1.
- R3: When word 1 bit 15 (ownership) reads 0, none_owned pulses for one cycle. No other memory access follows, desc_valid stays 0 and ring_idx is unchanged.
- R4: When word 1 bit 15 reads 1, the walker reads word 0 and word 2 and raises desc_valid. It then drives buf_addr = {word1[7:0], word0}.
- R5: buf_len is the 16-bit two's-complement negation of {4'hF, word2[11:0]}, so a stored 12'hFFF gives 1 and a stored 12'h000 gives 4096.
- R6: buf_sop equals word 1 bit 9 and buf_eop equals word 1 bit 8.
- R7: After each completion ring_idx becomes (ring_idx+1) mod 2^ring_code, so code 0 always stays on entry 0.
- R8: With dir_tx = 0 (receive), word 3 is written as {4'b0, cmp_count}. Word 1 is written as {0, OR of cmp_flags[3:0], cmp_flags[3:0], original bits 9:0}. cmp_flags[3] is framing error (bit 13), [2] overflow (bit 12), [1] CRC (bit 11) and [0] buffer error (bit 10).
- R9: With dir_tx = 1 (transmit), word 1 is written as {0, OR of cmp_flags[4:0], 0, cmp_retry[2:0], original bits 9:0}. cmp_retry[2] is more than one retry (bit 12), [1] one retry (bit 11) and [0] deferred (bit 10). Word 3 is written as {cmp_flags[4] buffer, cmp_flags[3] underflow, 0, cmp_flags[2] late collision, cmp_flags[1] lost carrier, cmp_flags[0] retry limit, 10'b0}.
- R10: A completion writes word 3 first and word 1 last, with bit 15 of word 1 cleared. cmp_done pulses in the cycle after the word 1 write is acknowledged.
- R11: fetch_req has no effect unless the walker is idle, and cmp_req has no effect unless desc_valid is 1.
- R12: Once raised, mem_req stays high until mem_ack, and mem_addr, mem_we and mem_wdata hold steady until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dir_tx | input | 1 | 0 selects receive write-back format, 1 transmit |
| ring_base | input | 24 | Ring byte address; bits 2:0 ignored |
| ring_code | input | 3 | Ring size code, 2^code entries |
| fetch_req | input | 1 | Pulse: examine the descriptor at the current index |
| desc_valid | output | 1 | An owned descriptor is held and decoded |
| buf_addr | output | 24 | Buffer address from words 0 and 1 |
| buf_len | output | 16 | Positive buffer length in bytes |
| buf_sop | output | 1 | Start-of-packet flag |
| buf_eop | output | 1 | End-of-packet flag |
| ring_idx | output | 7 | Current ring index |
| none_owned | output | 1 | Pulse: descriptor still owned by host |
| cmp_req | input | 1 | Pulse: buffer finished, write back status |
| cmp_flags | input | 5 | Error flags for write-back |
| cmp_retry | input | 3 | Transmit retry/defer flags |
| cmp_count | input | 12 | Receive message byte count |
| cmp_done | output | 1 | Pulse: descriptor released to host |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 24 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
The assertions watch every cycle for the steadiness of a pending memory request and for even word addresses. They also check that the status-word write always clears ownership and, on receive, carries an error summary consistent with its flags. They further confirm that completion follows a write acknowledge, that an empty report stops memory traffic, and that a stray completion request in idle starts nothing. Only the bench scenarios can show the decoded address and length values, the exact descriptor addresses and wrap for each ring size, and the write-back word contents in both directions. They also show the word 3 before word 1 write order and that the index holds after an empty poll. These scenarios use random ring placements, ownership patterns, memory latencies and flag values.

// File: rtl/ring_walker.sv
module ring_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dir_tx,
  input  logic [23:0] ring_base,
  input  logic [2:0]  ring_code,
  input  logic        fetch_req,
  output logic        desc_valid,
  output logic [23:0] buf_addr,
  output logic [15:0] buf_len,
  output logic        buf_sop,
  output logic        buf_eop,
  output logic [6:0]  ring_idx,
  output logic        none_owned,
  input  logic        cmp_req,
  input  logic [4:0]  cmp_flags,
  input  logic [2:0]  cmp_retry,
  input  logic [11:0] cmp_count,
  output logic        cmp_done,
  output logic        mem_req,
  output logic        mem_we,
  output logic [23:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int AW = 24;
  localparam int IW = 7;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD0, S_RD2, S_READY, S_WR3, S_WR1} st_t;

  st_t         st;
  logic [IW-1:0] idx;
  logic [15:0] w0;
  logic [9:0]  w1;
  logic [11:0] w2;
  logic [15:0] wb1, wb3;
  logic        empty_q, done_q;
  logic [1:0]  woff;
  logic [AW-1:0] base_al;
  logic [IW-1:0] idx_mask, idx_nxt;
  logic [15:0] wb1_new, wb3_new;

  assign base_al  = ring_base & ~24'h7;
  assign idx_mask = IW'((8'd1 << ring_code) - 8'd1);
  assign idx_nxt  = (idx + 1'b1) & idx_mask;

  always_comb begin
    case (st)
      S_RD0:   woff = 2'd0;
      S_RD2:   woff = 2'd2;
      S_WR3:   woff = 2'd3;
      default: woff = 2'd1;
    endcase
  end

  assign mem_req   = (st == S_RD1) || (st == S_RD0) || (st == S_RD2) ||
                     (st == S_WR3) || (st == S_WR1);
  assign mem_we    = (st == S_WR3) || (st == S_WR1);
  assign mem_addr  = base_al + {14'b0, idx, 3'b0} + {21'b0, woff, 1'b0};
  assign mem_wdata = (st == S_WR3) ? wb3 : (st == S_WR1) ? wb1 : 16'h0;

  always_comb begin
    if (dir_tx) begin
      wb1_new = {1'b0, |cmp_flags, 1'b0, cmp_retry, w1};
      wb3_new = {cmp_flags[4:3], 1'b0, cmp_flags[2:0], 10'b0};
    end else begin
      wb1_new = {1'b0, |cmp_flags[3:0], cmp_flags[3:0], w1};
      wb3_new = {4'b0, cmp_count};
    end
  end

  assign desc_valid = (st == S_READY);
  assign buf_addr   = {w1[7:0], w0};
  assign buf_len    = 16'(-{4'hF, w2});
  assign buf_sop    = w1[9];
  assign buf_eop    = w1[8];
  assign ring_idx   = idx;
  assign none_owned = empty_q;
  assign cmp_done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      w0      <= '0;
      w1      <= '0;
      w2      <= '0;
      wb1     <= '0;
      wb3     <= '0;
      empty_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      empty_q <= 1'b0;
      done_q  <= 1'b0;
      case (st)
        S_IDLE: if (fetch_req) st <= S_RD1;
        S_RD1: if (mem_ack) begin
          if (mem_rdata[15]) begin
            w1 <= mem_rdata[9:0];
            st <= S_RD0;
          end else begin
            empty_q <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_RD0: if (mem_ack) begin
          w0 <= mem_rdata;
          st <= S_RD2;
        end
        S_RD2: if (mem_ack) begin
          w2 <= mem_rdata[11:0];
          st <= S_READY;
        end
        S_READY: if (cmp_req) begin
          wb1 <= wb1_new;
          wb3 <= wb3_new;
          st  <= S_WR3;
        end
        S_WR3: if (mem_ack) st <= S_WR1;
        S_WR1: if (mem_ack) begin
          idx    <= idx_nxt;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_walker_chk.sv
module ring_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dir_tx,
  input logic        fetch_req,
  input logic        desc_valid,
  input logic        none_owned,
  input logic        cmp_req,
  input logic        cmp_done,
  input logic        mem_req,
  input logic        mem_we,
  input logic [23:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ack
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!mem_req && !desc_valid));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0));

  p_empty_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    none_owned |-> (!mem_req && !desc_valid));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[2:1] == 2'd1) |-> (mem_wdata[15] == 1'b0));

  p_rx_errsum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_tx && mem_req && mem_we && mem_addr[2:1] == 2'd1) |-> (mem_wdata[14] == (|mem_wdata[13:10])));

  p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |-> $past(mem_req && mem_we && mem_ack));

  p_valid_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_valid) |-> $past(mem_req && !mem_we && mem_ack));

  p_stray_cmp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_valid && !mem_req && cmp_req && !fetch_req) |=> !mem_req);
endmodule

bind ring_walker ring_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .fetch_req(fetch_req),
  .desc_valid(desc_valid), .none_owned(none_owned), .cmp_req(cmp_req),
  .cmp_done(cmp_done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_ring_walker.sv
`timescale 1ns/1ps
module sim_ring_walker;
  logic clk = 0;
  logic rst_n = 0;
  logic dir_tx = 0;
  logic [23:0] ring_base = 0;
  logic [2:0] ring_code = 0;
  logic fetch_req = 0, cmp_req = 0;
  logic [4:0] cmp_flags = 0;
  logic [2:0] cmp_retry = 0;
  logic [11:0] cmp_count = 0;
  logic desc_valid, buf_sop, buf_eop, none_owned, cmp_done;
  logic [23:0] buf_addr;
  logic [15:0] buf_len;
  logic [6:0] ring_idx;
  logic mem_req, mem_we, mem_ack = 0;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 0;

  int checks = 0, fails = 0, acc_cnt = 0;
  int last_off = -1, prev_off = -1;
  logic [23:0] base_al = 0;
  logic [6:0] exp_idx = 0;
  logic [15:0] mem [0:4095];

  always #2 clk = ~clk;

  ring_walker u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] f_len(input logic [15:0] w2);
    return 16'(17'h10000 - {1'b0, 4'hF, w2[11:0]});
  endfunction

  function automatic logic [15:0] f_wb1(input bit tx, input logic [15:0] w1, input logic [4:0] fl, input logic [2:0] rt);
    logic [15:0] r;
    r = {6'b0, w1[9:0]};
    if (tx) begin
      r[14] = (fl != 0);
      r[12:10] = rt;
    end else begin
      r[14] = (fl[3:0] != 0);
      r[13:10] = fl[3:0];
    end
    return r;
  endfunction

  function automatic logic [15:0] f_wb3(input bit tx, input logic [4:0] fl, input logic [11:0] cnt);
    logic [15:0] r;
    r = 16'h0;
    if (tx) begin
      r[15] = fl[4]; r[14] = fl[3]; r[12] = fl[2]; r[11] = fl[1]; r[10] = fl[0];
    end else r[11:0] = cnt;
    return r;
  endfunction

  // memory responder, checks each access address (R2)
  initial begin : mem_model
    bit ack_q = 0;
    int dly = 0;
    logic [23:0] exp_a;
    forever begin
      @(negedge clk);
      if (ack_q) begin
        mem_ack = 0; ack_q = 0;
      end else if (mem_req && rst_n) begin
        if (dly == 0) begin
          exp_a = base_al + {14'b0, exp_idx, 3'b0} + {21'b0, mem_addr[2:1], 1'b0};
          chk(mem_addr == exp_a, "R2 access address", mem_addr, exp_a);
          if (mem_we) begin
            mem[mem_addr[12:1]] = mem_wdata;
            prev_off = last_off; last_off = mem_addr[2:1];
          end else mem_rdata = mem[mem_addr[12:1]];
          acc_cnt++;
          mem_ack = 1; ack_q = 1;
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  task automatic wait_evt(output bit gv, output bit ge, output bit gd);
    gv = 0; ge = 0; gd = 0;
    for (int t = 0; t < 300; t++) begin
      if (desc_valid) begin gv = 1; break; end
      if (none_owned) begin ge = 1; break; end
      if (cmp_done) begin gd = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_fetch(output bit gv, output bit ge);
    bit gd;
    fetch_req = 1; @(negedge clk); fetch_req = 0;
    wait_evt(gv, ge, gd);
  endtask

  initial begin : watchdog
    #(4ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    bit gv, ge, gd;
    int a0, n, steps, wa;
    bit dir;
    logic [2:0] code;
    logic [15:0] w1o, w0o, w2o, e1, e3;
    logic [4:0] fl;
    logic [2:0] rt;
    logic [11:0] cnt;
    logic [2:0] codes [5] = '{3'd0, 3'd1, 3'd2, 3'd7, 3'd3};
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) begin
      dir = r[0];
      code = (r < 5) ? codes[r] : 3'($urandom % 8);
      n = 1 << code;
      ring_base = 24'($urandom);
      ring_base[12:3] = 10'($urandom % 896);
      base_al = ring_base & ~24'h7;
      for (int e = 0; e < n; e++) begin
        wa = (int'(base_al[12:0]) + e * 8) >> 1;
        mem[wa]     = 16'($urandom);
        mem[wa + 1] = {($urandom % 4) != 0, 15'($urandom)};
        mem[wa + 2] = {4'hF, 12'($urandom)};
        mem[wa + 3] = 16'($urandom);
        if (r == 1) mem[wa + 2] = (e == 0) ? 16'hF000 : 16'hFFFF;
      end
      @(negedge clk);
      rst_n = 0; dir_tx = dir; ring_code = code; exp_idx = 0;
      repeat (3) @(negedge clk);
      chk(!desc_valid && !mem_req && ring_idx == 0, "R1 reset state", {desc_valid, mem_req, ring_idx}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!desc_valid && !mem_req && ring_idx == 0, "R1 after reset", {desc_valid, mem_req, ring_idx}, 0);
      if (r == 0) begin
        a0 = acc_cnt;
        cmp_req = 1; @(negedge clk); cmp_req = 0;
        repeat (5) @(negedge clk);
        chk(acc_cnt == a0 && !mem_req && !desc_valid, "R11 stray cmp_req in idle", acc_cnt - a0, 0);
      end
      steps = (n + 2 < 24) ? n + 2 : 24;
      for (int s = 0; s < steps; s++) begin
        wa = (int'(base_al[12:0]) + int'(exp_idx) * 8) >> 1;
        a0 = acc_cnt;
        do_fetch(gv, ge);
        if (!mem[wa + 1][15]) begin
          chk(ge && !gv, "R3 none_owned pulse", {gv, ge}, 2'b01);
          chk(acc_cnt - a0 == 1, "R3 single access", acc_cnt - a0, 1);
          repeat (3) @(negedge clk);
          chk(ring_idx == exp_idx && !desc_valid && !mem_req, "R3 index held", ring_idx, exp_idx);
          mem[wa + 1][15] = 1'b1;
          a0 = acc_cnt;
          do_fetch(gv, ge);
        end
        w0o = mem[wa]; w1o = mem[wa + 1]; w2o = mem[wa + 2];
        chk(gv, "R4 desc_valid", gv, 1);
        chk(acc_cnt - a0 == 3, "R4 three reads", acc_cnt - a0, 3);
        chk(buf_addr == {w1o[7:0], w0o}, "R4 buf_addr", buf_addr, {w1o[7:0], w0o});
        chk(buf_len == f_len(w2o), "R5 buf_len", buf_len, f_len(w2o));
        chk({buf_sop, buf_eop} == w1o[9:8], "R6 sop eop", {buf_sop, buf_eop}, w1o[9:8]);
        if (r == 0 && s == 0) begin
          a0 = acc_cnt;
          fetch_req = 1; @(negedge clk); fetch_req = 0;
          repeat (5) @(negedge clk);
          chk(acc_cnt == a0 && desc_valid && !mem_req, "R11 fetch_req while valid", acc_cnt - a0, 0);
        end
        fl = (s % 3 == 0) ? 5'd0 : 5'($urandom);
        rt = 3'($urandom);
        cnt = 12'($urandom);
        cmp_flags = fl; cmp_retry = rt; cmp_count = cnt;
        cmp_req = 1; @(negedge clk); cmp_req = 0;
        cmp_flags = 5'($urandom); cmp_retry = 3'($urandom); cmp_count = 12'($urandom);
        wait_evt(gv, ge, gd);
        chk(gd, "R10 cmp_done", gd, 1);
        e1 = f_wb1(dir, w1o, fl, rt);
        e3 = f_wb3(dir, fl, cnt);
        chk(mem[wa + 1] == e1, dir ? "R9 tx word1" : "R8 rx word1", mem[wa + 1], e1);
        chk(mem[wa + 3] == e3, dir ? "R9 tx word3" : "R8 rx word3", mem[wa + 3], e3);
        chk(prev_off == 3 && last_off == 1, "R10 write order", {prev_off[3:0], last_off[3:0]}, 8'h31);
        exp_idx = 7'((int'(exp_idx) + 1) % n);
        chk(ring_idx == exp_idx, "R7 index advance", ring_idx, exp_idx);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule